// File: doc/BRIEF.md
# Remote Terminal Subaddress Lookup Engine

This block sits beside a remote-terminal protocol engine and a shared single-port RAM. When the terminal strobes the start of a message, the engine captures the received command word, the receiving channel and a time tag. It reads the active area's stack pointer, then writes a four-word descriptor at that pointer: a status word flagged "message in progress", the time tag, and the command word. It then reads the data-block pointer for the message from a lookup table and loads it into the transfer address register.

The lookup table is indexed by the active double-buffer area, the command word's transmit/receive bit and its five-bit subaddress. Receive pointers sit in the first 32 words of each table and transmit pointers in the next 32. At the end-of-message strobe the engine rewrites the status word as complete, with the error flag, and refreshes the time tag. It advances the area's stack pointer by one descriptor within a 64-entry ring and pulses the enabled interrupts.

The CPU's area selection is taken up only while the engine is idle, so one message always uses one area from start to end.

Top module: `rt_lut_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, busy_o low, area_o 0, both interrupt outputs low, xfer_addr_o zero.
- R2: A start strobe while idle reads the stack pointer word at 0x0100 (area 0) or 0x0104 (area 1). In this order it then writes the status word to address SP, the start time tag to SP+1, and the command word to SP+3. The status word has bit 1 (in progress) set, bit 0 (complete) clear, bit 2 (error) clear, and bit 13 equal to the captured channel (1 = channel B).
- R3: The lookup address is 0x0100 | area<<7 | 1<<6 | TR<<5 | SA. TR is command bit 10 and SA is command bits 9:5. The word read there is loaded into xfer_addr_o.
- R4: An end strobe during a message writes three words, in this order. First the status word to SP: bit 0 set, bit 1 clear, bit 2 equal to msg_err_i at the end strobe, and bit 13 the channel. Next the end time tag to SP+1. Last, the advanced pointer to the area's stack pointer word.
- R5: The pointer advances by 4 modulo 256: bits 15:8 are kept and bits 7:0 wrap (0x0FFC becomes 0x0F00).
- R6: While idle, area_o takes area_req_i one cycle later. From the start strobe until the message completes, area_o holds, and a pending change is taken up once idle.
- R7: eom_irq_o pulses high for exactly one cycle, the cycle after the pointer write, when eom_irq_en_i is high. Otherwise it stays low.
- R8: err_irq_o pulses for one cycle with the same timing as R7 when msg_err_i was high at the end strobe and err_irq_en_i is high.
- R9: An end strobe while idle causes no memory access and no change to busy_o, xfer_addr_o or the stack pointers. It gives no eom_irq_o, and gives a one-cycle err_irq_o pulse if err_irq_en_i is high.
- R10: xfer_addr_o changes only while a message is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| som_i | input | 1 | Start-of-message strobe, one cycle |
| eom_i | input | 1 | End-of-message strobe, one cycle |
| cmd_word_i | input | 16 | Received command word, valid with som_i |
| chan_b_i | input | 1 | Receiving channel, 1 = B, valid with som_i |
| msg_err_i | input | 1 | Message error, valid with eom_i |
| time_tag_i | input | 16 | Time tag value, sampled at each strobe |
| area_req_i | input | 1 | CPU area selection |
| eom_irq_en_i | input | 1 | End-of-message interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | 16 | RAM word address |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, one cycle after a read request |
| xfer_addr_o | output | 16 | Transfer address register |
| busy_o | output | 1 | Message being processed |
| area_o | output | 1 | Active area |
| eom_irq_o | output | 1 | End-of-message interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
The assertions assume one-cycle strobes, a start strobe only while idle, and an end strobe either while idle (a stray strobe) or after the start sequence has loaded the transfer address. They also assume the RAM returns read data exactly one cycle after a read request. The stimulus meets these conditions. It waits ten cycles after every start strobe before ending the message or moving the area selection, and it serves memory from a bench RAM with that latency. Within those rules the bench changes the area in mid-message, wraps a stack pointer, and sends stray end strobes with the error interrupt enabled and disabled.

// File: rtl/rt_lut_pkg.sv
package rt_lut_pkg;
  localparam int unsigned STAT_EOM_BIT  = 0;
  localparam int unsigned STAT_SOM_BIT  = 1;
  localparam int unsigned STAT_ERR_BIT  = 2;
  localparam int unsigned STAT_CHAN_BIT = 13;
  localparam int unsigned CMD_TR_BIT    = 10;
  localparam int unsigned CMD_SA_LSB    = 5;
  localparam int unsigned SA_W          = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_SP, ST_LD_SP, ST_WR_SOM, ST_WR_TAG0, ST_WR_CMD,
    ST_RD_LUT, ST_LD_LUT, ST_ACTIVE, ST_WR_EOM, ST_WR_TAG1, ST_WR_SP
  } seq_state_e;
endpackage

// File: rtl/rt_addr_gen.sv
module rt_addr_gen #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter logic [15:0] TABLE_BASE    = 16'h0100,
  parameter int unsigned AREA_STRIDE   = 4,
  parameter int unsigned STACK_ENTRIES = 64,
  parameter int unsigned ENTRY_WORDS   = 4
) (
  input  logic              area_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [ADDR_W-1:0] sp_ptr_addr_o,
  output logic [ADDR_W-1:0] lut_addr_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  import rt_lut_pkg::*;
  localparam int unsigned RING_W    = $clog2(STACK_ENTRIES * ENTRY_WORDS);
  localparam int unsigned STRIDE_SH = $clog2(AREA_STRIDE);
  localparam int unsigned HALF_SH   = SA_W + 1;
  localparam int unsigned AREA_SH   = SA_W + 2;

  logic [RING_W-1:0] ring_lo;

  assign sp_ptr_addr_o = ADDR_W'(TABLE_BASE) | (ADDR_W'(area_i) << STRIDE_SH);

  // table offset: area, table-half marker, direction, subaddress
  assign lut_addr_o = ADDR_W'(TABLE_BASE)
                    | (ADDR_W'(area_i) << AREA_SH)
                    | (ADDR_W'(1) << HALF_SH)
                    | (ADDR_W'(cmd_i[CMD_TR_BIT]) << SA_W)
                    | ADDR_W'(cmd_i[CMD_SA_LSB +: SA_W]);

  assign ring_lo   = sp_i[RING_W-1:0] + RING_W'(ENTRY_WORDS);
  assign sp_next_o = {sp_i[ADDR_W-1:RING_W], ring_lo};
endmodule

// File: rtl/rt_area_sel.sv
module rt_area_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic area_req_i,
  input  logic som_i,
  input  logic busy_i,
  output logic area_o
);
  logic area_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 area_q <= 1'b0;
    else if (!(busy_i || som_i)) area_q <= area_req_i;
  end

  assign area_o = area_q;

  assert_area_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(area_o));
endmodule

// File: rtl/rt_msg_seq.sv
module rt_msg_seq #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              som_i,
  input  logic              eom_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              chan_b_i,
  input  logic              msg_err_i,
  input  logic [DATA_W-1:0] time_tag_i,
  input  logic              eom_irq_en_i,
  input  logic              err_irq_en_i,
  input  logic [ADDR_W-1:0] sp_ptr_addr_i,
  input  logic [ADDR_W-1:0] lut_addr_i,
  input  logic [ADDR_W-1:0] sp_next_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              busy_o,
  output logic              eom_irq_o,
  output logic              err_irq_o
);
  import rt_lut_pkg::*;

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] cmd_q, tag_q;
  logic [ADDR_W-1:0] sp_q, xfer_q;
  logic              chan_q, err_q, eom_irq_q, err_irq_q;
  logic              stray;
  logic [DATA_W-1:0] stat_start, stat_end;

  assign stray = (state_q == ST_IDLE) && eom_i && !som_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (som_i) state_d = ST_RD_SP;
      ST_RD_SP:   state_d = ST_LD_SP;
      ST_LD_SP:   state_d = ST_WR_SOM;
      ST_WR_SOM:  state_d = ST_WR_TAG0;
      ST_WR_TAG0: state_d = ST_WR_CMD;
      ST_WR_CMD:  state_d = ST_RD_LUT;
      ST_RD_LUT:  state_d = ST_LD_LUT;
      ST_LD_LUT:  state_d = ST_ACTIVE;
      ST_ACTIVE:  if (eom_i) state_d = ST_WR_EOM;
      ST_WR_EOM:  state_d = ST_WR_TAG1;
      ST_WR_TAG1: state_d = ST_WR_SP;
      ST_WR_SP:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      tag_q     <= '0;
      sp_q      <= '0;
      xfer_q    <= '0;
      chan_q    <= 1'b0;
      err_q     <= 1'b0;
      eom_irq_q <= 1'b0;
      err_irq_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && som_i) begin
        cmd_q  <= cmd_word_i;
        chan_q <= chan_b_i;
        tag_q  <= time_tag_i;
      end
      if (state_q == ST_ACTIVE && eom_i) begin
        err_q <= msg_err_i;
        tag_q <= time_tag_i;
      end
      if (state_q == ST_LD_SP)  sp_q   <= mem_rdata_i;
      if (state_q == ST_LD_LUT) xfer_q <= mem_rdata_i;
      eom_irq_q <= (state_q == ST_WR_SP) && eom_irq_en_i;
      err_irq_q <= err_irq_en_i && (((state_q == ST_WR_SP) && err_q) || stray);
    end
  end

  always_comb begin
    stat_start = '0;
    stat_start[STAT_SOM_BIT]  = 1'b1;
    stat_start[STAT_CHAN_BIT] = chan_q;
    stat_end = '0;
    stat_end[STAT_EOM_BIT]  = 1'b1;
    stat_end[STAT_ERR_BIT]  = err_q;
    stat_end[STAT_CHAN_BIT] = chan_q;
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b1;
    mem_addr_o  = sp_q;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD_SP:   begin mem_we_o = 1'b0; mem_addr_o = sp_ptr_addr_i; end
      ST_WR_SOM:  mem_wdata_o = stat_start;
      ST_WR_TAG0: begin mem_addr_o = sp_q + ADDR_W'(1); mem_wdata_o = tag_q; end
      ST_WR_CMD:  begin mem_addr_o = sp_q + ADDR_W'(3); mem_wdata_o = cmd_q; end
      ST_RD_LUT:  begin mem_we_o = 1'b0; mem_addr_o = lut_addr_i; end
      ST_WR_EOM:  mem_wdata_o = stat_end;
      ST_WR_TAG1: begin mem_addr_o = sp_q + ADDR_W'(1); mem_wdata_o = tag_q; end
      ST_WR_SP:   begin mem_addr_o = sp_ptr_addr_i; mem_wdata_o = DATA_W'(sp_next_i); end
      default:    begin mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0; end
    endcase
  end

  assign cmd_o       = cmd_q;
  assign sp_o        = sp_q;
  assign xfer_addr_o = xfer_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign eom_irq_o   = eom_irq_q;
  assign err_irq_o   = err_irq_q;

  assert_stray_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stray |=> (!mem_req_o && !busy_o));

  assert_irq_after_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_irq_o |-> ($past(mem_we_o) && !busy_o));

  assert_xfer_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(xfer_addr_o));

  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |=> !err_irq_o);
endmodule

// File: rtl/rt_lut_engine.sv
module rt_lut_engine #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter logic [15:0] TABLE_BASE    = 16'h0100,
  parameter int unsigned STACK_ENTRIES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              som_i,
  input  logic              eom_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              chan_b_i,
  input  logic              msg_err_i,
  input  logic [DATA_W-1:0] time_tag_i,
  input  logic              area_req_i,
  input  logic              eom_irq_en_i,
  input  logic              err_irq_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              busy_o,
  output logic              area_o,
  output logic              eom_irq_o,
  output logic              err_irq_o
);
  logic [ADDR_W-1:0] sp_ptr_addr, lut_addr, sp_next, sp_cur;
  logic [DATA_W-1:0] cmd_cur;
  logic              busy, area;

  rt_area_sel u_area (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .area_req_i (area_req_i),
    .som_i      (som_i),
    .busy_i     (busy),
    .area_o     (area)
  );

  rt_addr_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TABLE_BASE(TABLE_BASE),
    .AREA_STRIDE(4), .STACK_ENTRIES(STACK_ENTRIES), .ENTRY_WORDS(4)
  ) u_addr (
    .area_i        (area),
    .cmd_i         (cmd_cur),
    .sp_i          (sp_cur),
    .sp_ptr_addr_o (sp_ptr_addr),
    .lut_addr_o    (lut_addr),
    .sp_next_o     (sp_next)
  );

  rt_msg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .som_i         (som_i),
    .eom_i         (eom_i),
    .cmd_word_i    (cmd_word_i),
    .chan_b_i      (chan_b_i),
    .msg_err_i     (msg_err_i),
    .time_tag_i    (time_tag_i),
    .eom_irq_en_i  (eom_irq_en_i),
    .err_irq_en_i  (err_irq_en_i),
    .sp_ptr_addr_i (sp_ptr_addr),
    .lut_addr_i    (lut_addr),
    .sp_next_i     (sp_next),
    .mem_rdata_i   (mem_rdata_i),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .cmd_o         (cmd_cur),
    .sp_o          (sp_cur),
    .xfer_addr_o   (xfer_addr_o),
    .busy_o        (busy),
    .eom_irq_o     (eom_irq_o),
    .err_irq_o     (err_irq_o)
  );

  assign busy_o = busy;
  assign area_o = area;
endmodule

// File: tb/rt_lut_engine_tb.sv
module rt_lut_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        som = 0, eom = 0, chan = 0, merr = 0, area_req = 0, eom_en = 1, err_en = 1;
  logic [15:0] cmd = '0, tag = '0;
  logic        mem_req, mem_we, busy, area, eom_irq, err_irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, xfer;

  rt_lut_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .som_i(som), .eom_i(eom), .cmd_word_i(cmd),
    .chan_b_i(chan), .msg_err_i(merr), .time_tag_i(tag), .area_req_i(area_req),
    .eom_irq_en_i(eom_en), .err_irq_en_i(err_en), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .xfer_addr_o(xfer), .busy_o(busy), .area_o(area),
    .eom_irq_o(eom_irq), .err_irq_o(err_irq)
  );

  int n_chk = 0, n_bad = 0, n_eom_irq = 0, n_err_irq = 0;
  bit finished = 0;
  logic [31:0] exp_wr[$];
  logic [15:0] sp_model[2];
  logic [15:0] ram [0:4095];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] lut_ref(input logic a, input logic [15:0] c);
    return 16'h0100 | (16'(a) << 7) | 16'h0040 | (16'(c[10]) << 5) | 16'(c[9:5]);
  endfunction

  function automatic logic [15:0] lut_fill(input logic [15:0] adr);
    return {4'h7, adr[11:0]};
  endfunction

  // bench RAM, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      ram[16'h0100] <= 16'h0200;
      ram[16'h0104] <= 16'h0FFC;
      for (int i = 0; i < 64; i++) begin
        ram[16'h0140 + i] <= lut_fill(16'h0140 + 16'(i));
        ram[16'h01C0 + i] <= lut_fill(16'h01C0 + 16'(i));
      end
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[11:0]];
    end
  end

  // compare every write and interrupt sample against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (eom_irq) n_eom_irq++;
      if (err_irq) n_err_irq++;
      if (mem_req && mem_we) begin
        if (exp_wr.size() == 0) chk(0, "R2/R4/R9 unexpected write", {mem_addr, mem_wdata}, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} === e, "R2/R4/R5 write", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic run_msg(input logic a, input logic [15:0] c, input logic ch, input logic er,
                         input logic [15:0] t0, input logic [15:0] t1, input logic swap_mid);
    logic [15:0] sp, ptr, nxt;
    int e0, r0;
    sp  = sp_model[a];
    ptr = 16'h0100 | (16'(a) << 2);
    nxt = {sp[15:8], sp[7:0] + 8'd4};
    exp_wr.push_back({sp, 16'h0002 | (16'(ch) << 13)});
    exp_wr.push_back({sp + 16'd1, t0});
    exp_wr.push_back({sp + 16'd3, c});
    @(negedge clk); som = 1; cmd = c; chan = ch; tag = t0;
    @(negedge clk); som = 0; cmd = '0;
    repeat (10) @(negedge clk);
    chk(xfer === lut_fill(lut_ref(a, c)), "R3 xfer addr", xfer, lut_fill(lut_ref(a, c)));
    chk(busy === 1'b1, "R2 busy in message", busy, 1);
    chk(exp_wr.size() == 0, "R2 start writes done", exp_wr.size(), 0);
    if (swap_mid) begin
      area_req = ~a;
      repeat (4) @(negedge clk);
      chk(area === a, "R6 area held mid-message", area, a);
    end
    e0 = n_eom_irq; r0 = n_err_irq;
    exp_wr.push_back({sp, 16'h0001 | (16'(er) << 2) | (16'(ch) << 13)});
    exp_wr.push_back({sp + 16'd1, t1});
    exp_wr.push_back({ptr, nxt});
    sp_model[a] = nxt;
    @(negedge clk); eom = 1; merr = er; tag = t1;
    @(negedge clk); eom = 0; merr = 0;
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, "R4 idle after end", busy, 0);
    chk(exp_wr.size() == 0, "R4 end writes done", exp_wr.size(), 0);
    chk(n_eom_irq - e0 == int'(eom_en), "R7 eom irq pulses", n_eom_irq - e0, int'(eom_en));
    chk(n_err_irq - r0 == int'(er && err_en), "R8 err irq pulses", n_err_irq - r0, int'(er && err_en));
  endtask

  task automatic stray_eom(input logic en);
    logic [15:0] x0;
    int e0, r0;
    x0 = xfer; e0 = n_eom_irq; r0 = n_err_irq;
    err_en = en;
    @(negedge clk); eom = 1; merr = 1;
    @(negedge clk); chk(busy === 1'b0, "R9 stray keeps idle", busy, 0); eom = 0; merr = 0;
    repeat (4) @(negedge clk);
    chk(xfer === x0, "R9 stray xfer unchanged", xfer, x0);
    chk(n_eom_irq == e0, "R9 stray no eom irq", n_eom_irq - e0, 0);
    chk(n_err_irq - r0 == int'(en), "R9 stray err irq", n_err_irq - r0, int'(en));
    err_en = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    sp_model[0] = 16'h0200;
    sp_model[1] = 16'h0FFC;
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0 && busy === 1'b0, "R1 reset idle", {mem_req, busy}, 0);
    chk(area === 1'b0 && eom_irq === 1'b0 && err_irq === 1'b0, "R1 reset area/irq", {area, eom_irq, err_irq}, 0);
    chk(xfer === 16'h0, "R1 reset xfer", xfer, 0);
    rst_n = 1;
    @(negedge clk);
    area_req = 1;
    @(negedge clk);
    chk(area === 1'b1, "R6 idle follow", area, 1);
    area_req = 0;
    repeat (2) @(negedge clk);
    chk(area === 1'b0, "R6 idle follow back", area, 0);
    // receive, subaddress 3, channel A, clean
    run_msg(0, 16'h1865, 0, 0, 16'h1111, 16'h2222, 0);
    // transmit, subaddress 31, channel B, error, area change deferred
    run_msg(0, 16'h0FE2, 1, 1, 16'h3333, 16'h4444, 1);
    repeat (2) @(negedge clk);
    chk(area === 1'b1, "R6 deferred swap taken", area, 1);
    stray_eom(1);
    stray_eom(0);
    // area B, pointer ring wrap, interrupts masked
    eom_en = 0; err_en = 0;
    run_msg(1, 16'hF40A, 0, 1, 16'h5555, 16'h6666, 0);
    eom_en = 1; err_en = 1;
    // area B again from the wrapped pointer
    run_msg(1, 16'h0020, 1, 0, 16'h7777, 16'h8888, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end
endmodule